// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block caches recent virtual-to-physical page translations for a 32-bit machine with 4 KB pages. Every entry holds a valid flag, the process id that owns it, a virtual page number and a physical page number. A lookup presents a virtual address together with the process id now running. All entries are compared at the same time, and one clock later the block returns either the physical address or a miss flag. On a miss, an outside walker or trap handler finds the translation and installs it through the fill port.

The process id is part of every tag. Translations that belong to different processes can therefore sit side by side, and switching the running process needs no flush. When the fill port needs a slot, it reuses an entry that already holds the same process id and page. If there is none, it takes the lowest free entry. If all entries are in use, it evicts the entry named by a rotating pointer. A single input clears every entry at once.

Top module: `pid_tlb`

## Requirements
- R1: After reset every entry is invalid, the rotating pointer names entry 0 and `rsp_valid`, `rsp_hit` and `rsp_miss` are low. The first lookup after reset misses.
- R2: A lookup hits only when some entry is valid and both its process id and its page number equal `cur_pid` and `lk_vaddr[31:12]`. An entry of a different process with the same page number never matches.
- R3: On a hit, `rsp_paddr[31:12]` is the stored physical page number and `rsp_paddr[11:0]` equals `lk_vaddr[11:0]` of that lookup. On a miss, `rsp_paddr` is zero.
- R4: A lookup presented in cycle t gives `rsp_valid`=1 in cycle t+1, with exactly one of `rsp_hit` and `rsp_miss` high. In a cycle after one with no lookup, all three flags are low.
- R5: Changing `cur_pid` removes no entry. A later lookup under an earlier process id still hits.
- R6: A fill whose process id and page number match a valid entry overwrites that entry's physical page number. No key ever matches more than one entry.
- R7: A fill with no matching entry goes to the lowest-numbered invalid entry if one exists, and the rotating pointer does not move.
- R8: When every entry is valid and no entry matches, a fill replaces the entry named by the rotating pointer. The pointer then advances by one and wraps from the last entry to 0.
- R9: `flush_all` invalidates every entry at the next edge. A fill in the same cycle is discarded. The rotating pointer keeps its value.
- R10: A lookup and a fill in the same cycle: the lookup sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| cur_pid | input | 8 | Process id of the running process |
| flush_all | input | 1 | Invalidate all entries |
| wr_en | input | 1 | Install a translation |
| wr_pid | input | 8 | Process id of the translation |
| wr_vpn | input | 20 | Virtual page number of the translation |
| wr_ppn | input | 20 | Physical page number of the translation |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup found a translation |
| rsp_miss | output | 1 | Lookup found no translation |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
A hand-built vector table stores the same page number under two process ids. It then looks the page up under both ids, under a third id and at a neighbouring page. This separates a match on the page alone from a match on process and page together, and it checks that switching processes keeps earlier entries. Directed sequences fill the TLB past its capacity, both right after reset and after a flush. The entry each extra fill evicts shows whether free slots are used first and whether the rotating pointer survives a flush. Further cases drive a fill together with a lookup or a flush in the same cycle. A long random phase, drawn from a key space larger than the TLB, is compared lookup by lookup against a reference model of the policy.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int unsigned TLB_ENTRIES = 8;
    localparam int unsigned TLB_PID_W   = 8;
    localparam int unsigned TLB_VA_W    = 32;
    localparam int unsigned TLB_OFF_W   = 12;

    // How a fill picked its slot
    typedef enum logic [1:0] {
        SLOT_REUSE  = 2'd0,
        SLOT_FREE   = 2'd1,
        SLOT_ROTATE = 2'd2
    } slot_kind_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int unsigned N     = 8,
    parameter int unsigned PID_W = 8,
    parameter int unsigned VPN_W = 20
) (
    input  logic [N-1:0]            ent_valid,
    input  logic [N-1:0][PID_W-1:0] ent_pid,
    input  logic [N-1:0][VPN_W-1:0] ent_vpn,
    input  logic [PID_W-1:0]        key_pid,
    input  logic [VPN_W-1:0]        key_vpn,
    output logic [N-1:0]            match
);
    // one comparator per entry, all working in parallel
    generate
        for (genvar i = 0; i < N; i++) begin : g_cmp
            assign match[i] = ent_valid[i]
                              && (ent_pid[i] == key_pid)
                              && (ent_vpn[i] == key_vpn);
        end
    endgenerate
endmodule

// File: rtl/tlb_prienc.sv
module tlb_prienc #(
    parameter int unsigned N = 8,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // lowest set bit wins
    always_comb begin
        idx = '0;
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int unsigned N = 8,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     ent_valid,
    input  logic [N-1:0]     key_match,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] slot,
    output slot_kind_e       kind
);
    logic [IDX_W-1:0] reuse_idx, free_idx;
    logic             reuse_any, free_any;

    tlb_prienc #(.N(N)) u_reuse (.req(key_match),  .idx(reuse_idx), .any(reuse_any));
    tlb_prienc #(.N(N)) u_free  (.req(~ent_valid), .idx(free_idx),  .any(free_any));

    always_comb begin
        if (reuse_any) begin
            slot = reuse_idx;
            kind = SLOT_REUSE;
        end else if (free_any) begin
            slot = free_idx;
            kind = SLOT_FREE;
        end else begin
            slot = rr_ptr;
            kind = SLOT_ROTATE;
        end
    end
endmodule

// File: rtl/pid_tlb.sv
module pid_tlb
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = TLB_ENTRIES,
    parameter int unsigned PID_W   = TLB_PID_W,
    parameter int unsigned VA_W    = TLB_VA_W,
    parameter int unsigned OFF_W   = TLB_OFF_W,
    localparam int unsigned VPN_W  = VA_W - OFF_W,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [PID_W-1:0] cur_pid,
    input  logic             flush_all,
    input  logic             wr_en,
    input  logic [PID_W-1:0] wr_pid,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [VPN_W-1:0] wr_ppn,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic [VA_W-1:0]  rsp_paddr
);
    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][PID_W-1:0] pid;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][VPN_W-1:0] ppn;
        logic [IDX_W-1:0]              rr_ptr;
        logic                          rsp_valid;
        logic                          rsp_hit;
        logic [VA_W-1:0]               rsp_paddr;
    } tlb_state_t;

    tlb_state_t st_d, st_q;

    logic [ENTRIES-1:0] lk_match, fill_match;
    logic [IDX_W-1:0]   lk_idx, fill_slot;
    logic               lk_any;
    slot_kind_e         fill_kind;

    tlb_cam #(.N(ENTRIES), .PID_W(PID_W), .VPN_W(VPN_W)) u_lk_cam (
        .ent_valid(st_q.valid), .ent_pid(st_q.pid), .ent_vpn(st_q.vpn),
        .key_pid(cur_pid), .key_vpn(lk_vaddr[VA_W-1:OFF_W]), .match(lk_match)
    );

    tlb_prienc #(.N(ENTRIES)) u_lk_enc (.req(lk_match), .idx(lk_idx), .any(lk_any));

    tlb_cam #(.N(ENTRIES), .PID_W(PID_W), .VPN_W(VPN_W)) u_fill_cam (
        .ent_valid(st_q.valid), .ent_pid(st_q.pid), .ent_vpn(st_q.vpn),
        .key_pid(wr_pid), .key_vpn(wr_vpn), .match(fill_match)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .ent_valid(st_q.valid), .key_match(fill_match), .rr_ptr(st_q.rr_ptr),
        .slot(fill_slot), .kind(fill_kind)
    );

    always_comb begin
        st_d = st_q;

        // lookup result, taken from contents before any fill this cycle
        st_d.rsp_valid = lk_req;
        st_d.rsp_hit   = lk_req && lk_any;
        st_d.rsp_paddr = (lk_req && lk_any)
                         ? {st_q.ppn[lk_idx], lk_vaddr[OFF_W-1:0]}
                         : '0;

        // contents update: flush overrides fill
        if (flush_all) begin
            st_d.valid = '0;
        end else if (wr_en) begin
            st_d.valid[fill_slot] = 1'b1;
            st_d.pid[fill_slot]   = wr_pid;
            st_d.vpn[fill_slot]   = wr_vpn;
            st_d.ppn[fill_slot]   = wr_ppn;
            if (fill_kind == SLOT_ROTATE) begin
                st_d.rr_ptr = (st_q.rr_ptr == IDX_W'(ENTRIES - 1))
                              ? '0 : st_q.rr_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
        end else begin
            st_q           <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_miss  = st_q.rsp_valid && !st_q.rsp_hit;
    assign rsp_paddr = st_q.rsp_paddr;
endmodule

// File: rtl/tlb_sva.sv
module tlb_sva #(
    parameter int unsigned N     = 8,
    parameter int unsigned VA_W  = 32,
    parameter int unsigned OFF_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_req,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            flush_all,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic [VA_W-1:0] rsp_paddr,
    input logic [N-1:0]    lk_match
);
    // R4
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (rsp_valid && (rsp_hit != rsp_miss)));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!rsp_valid && !rsp_hit && !rsp_miss));

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

    // R9
    flush_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all ##1 lk_req |=> rsp_miss);

    // R6
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
endmodule

bind pid_tlb tlb_sva #(.N(ENTRIES), .VA_W(VA_W), .OFF_W(OFF_W)) u_tlb_sva (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .flush_all(flush_all), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr), .lk_match(lk_match)
);

// File: tb/test_pid_tlb.sv
module test_pid_tlb;
    localparam int NE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  cur_pid = '0;
    logic        flush_all = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_pid = '0;
    logic [19:0] wr_vpn = '0;
    logic [19:0] wr_ppn = '0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [31:0] rsp_paddr;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pid_tlb i_pid_tlb (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .cur_pid(cur_pid), .flush_all(flush_all), .wr_en(wr_en),
        .wr_pid(wr_pid), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_paddr(rsp_paddr)
    );

    // reference model of the contents and policy
    logic        m_valid [NE];
    logic [7:0]  m_pid   [NE];
    logic [19:0] m_vpn   [NE];
    logic [19:0] m_ppn   [NE];
    int          m_ptr;

    // {is_lookup, pid, vpn, ppn_or_expected_ppn, expected_hit}
    localparam int NV = 9;
    localparam logic [49:0] VEC [NV] = '{
        {1'b0, 8'd1, 20'h00003, 20'h00005, 1'b0},
        {1'b0, 8'd2, 20'h00003, 20'h00008, 1'b0},
        {1'b1, 8'd1, 20'h00003, 20'h00005, 1'b1},
        {1'b1, 8'd2, 20'h00003, 20'h00008, 1'b1},
        {1'b1, 8'd3, 20'h00003, 20'h00000, 1'b0},
        {1'b1, 8'd1, 20'h00004, 20'h00000, 1'b0},
        {1'b0, 8'd1, 20'h00003, 20'h0000A, 1'b0},
        {1'b1, 8'd1, 20'h00003, 20'h0000A, 1'b1},
        {1'b1, 8'd2, 20'h00003, 20'h00008, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        for (int i = 0; i < NE; i++) m_valid[i] = 1'b0;
        m_ptr = 0;
    endtask

    task automatic m_flush();
        for (int i = 0; i < NE; i++) m_valid[i] = 1'b0;
    endtask

    task automatic m_fill(input logic [7:0] p, input logic [19:0] v, input logic [19:0] q);
        int slot = -1;
        for (int i = 0; i < NE; i++)
            if (slot < 0 && m_valid[i] && m_pid[i] == p && m_vpn[i] == v) slot = i;
        for (int i = 0; i < NE; i++)
            if (slot < 0 && !m_valid[i]) slot = i;
        if (slot < 0) begin
            slot = m_ptr;
            m_ptr = (m_ptr + 1) % NE;
        end
        m_valid[slot] = 1'b1;
        m_pid[slot] = p;
        m_vpn[slot] = v;
        m_ppn[slot] = q;
    endtask

    task automatic m_look(input logic [7:0] p, input logic [19:0] v,
                          output logic h, output logic [19:0] q);
        h = 1'b0;
        q = '0;
        for (int i = 0; i < NE; i++)
            if (m_valid[i] && m_pid[i] == p && m_vpn[i] == v) begin
                h = 1'b1;
                q = m_ppn[i];
            end
    endtask

    // all tasks start and end at a falling edge
    task automatic do_fill(input logic [7:0] p, input logic [19:0] v, input logic [19:0] q);
        wr_en = 1'b1; wr_pid = p; wr_vpn = v; wr_ppn = q;
        @(negedge clk);
        wr_en = 1'b0;
        m_fill(p, v, q);
    endtask

    task automatic do_flush();
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        m_flush();
    endtask

    task automatic do_look(input logic [7:0] p, input logic [19:0] v, input logic [11:0] off,
                           input string tag, output logic h_act, output logic [19:0] q_act);
        logic        h_exp;
        logic [19:0] q_exp;
        m_look(p, v, h_exp, q_exp);
        lk_req = 1'b1; cur_pid = p; lk_vaddr = {v, off};
        @(negedge clk);
        lk_req = 1'b0;
        chk({tag, " R4 valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " R2 hit"}, 32'(rsp_hit), 32'(h_exp));
        chk({tag, " R4 miss"}, 32'(rsp_miss), 32'(!h_exp));
        chk({tag, " R3 paddr"}, rsp_paddr, h_exp ? {q_exp, off} : 32'd0);
        h_act = rsp_hit;
        q_act = rsp_paddr[31:12];
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic        h;
        logic [19:0] q;
        m_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rsp_hit after reset", 32'(rsp_hit), 32'd0);
        chk("R1 rsp_miss after reset", 32'(rsp_miss), 32'd0);
        do_look(8'd0, 20'h0, 12'h000, "R1 first lookup", h, q);
        chk("R1 first lookup misses", 32'(h), 32'd0);
        @(negedge clk);
        chk("R4 idle after lookup", 32'(rsp_valid), 32'd0);

        // R7/R8: fill past capacity right after reset
        for (int i = 0; i < NE; i++) do_fill(8'd5, 20'h100 + 20'(i), 20'h200 + 20'(i));
        do_fill(8'd5, 20'h1FF, 20'h2FF);
        do_look(8'd5, 20'h100, 12'h123, "R8 first victim", h, q);
        chk("R8 entry 0 evicted", 32'(h), 32'd0);
        do_look(8'd5, 20'h101, 12'h456, "R8 survivor", h, q);
        chk("R8 entry 1 kept", 32'(h), 32'd1);
        do_fill(8'd5, 20'h1FE, 20'h2FE);
        do_look(8'd5, 20'h101, 12'h000, "R8 second victim", h, q);
        chk("R8 entry 1 evicted", 32'(h), 32'd0);
        do_look(8'd5, 20'h1FF, 12'hFFF, "R8 new entry", h, q);
        chk("R8 new entry hits", 32'(h), 32'd1);

        // R9/R7: flush keeps pointer; free slots used before rotation
        do_flush();
        do_look(8'd5, 20'h1FF, 12'h000, "R9 after flush", h, q);
        chk("R9 flushed entry misses", 32'(h), 32'd0);
        for (int i = 0; i < NE; i++) do_fill(8'd6, 20'h300 + 20'(i), 20'h400 + 20'(i));
        do_fill(8'd6, 20'h3FF, 20'h4FF);
        do_look(8'd6, 20'h302, 12'h010, "R9 pointer kept", h, q);
        chk("R9 entry 2 evicted", 32'(h), 32'd0);
        do_look(8'd6, 20'h300, 12'h010, "R7 free slots first", h, q);
        chk("R7 entry 0 kept", 32'(h), 32'd1);

        // R9: flush beats a simultaneous fill
        flush_all = 1'b1; wr_en = 1'b1; wr_pid = 8'd7; wr_vpn = 20'h555; wr_ppn = 20'h666;
        @(negedge clk);
        flush_all = 1'b0; wr_en = 1'b0;
        m_flush();
        do_look(8'd7, 20'h555, 12'h000, "R9 fill dropped", h, q);
        chk("R9 fill during flush dropped", 32'(h), 32'd0);

        // R10: lookup and fill together
        wr_en = 1'b1; wr_pid = 8'd9; wr_vpn = 20'hABCDE; wr_ppn = 20'h12345;
        lk_req = 1'b1; cur_pid = 8'd9; lk_vaddr = {20'hABCDE, 12'h321};
        @(negedge clk);
        wr_en = 1'b0; lk_req = 1'b0;
        chk("R10 same-cycle lookup misses", 32'(rsp_miss), 32'd1);
        m_fill(8'd9, 20'hABCDE, 20'h12345);
        do_look(8'd9, 20'hABCDE, 12'h321, "R10 later lookup", h, q);
        chk("R10 later lookup hits", 32'(h), 32'd1);

        // vector table: R2, R5, R6
        do_flush();
        for (int k = 0; k < NV; k++) begin
            if (VEC[k][49]) begin
                do_look(VEC[k][48:41], VEC[k][40:21], 12'(k * 37), "R5 table", h, q);
                chk("R2 table hit", 32'(h), 32'(VEC[k][0]));
                if (VEC[k][0]) chk("R6 table ppn", 32'(q), 32'(VEC[k][20:1]));
            end else begin
                do_fill(VEC[k][48:41], VEC[k][40:21], VEC[k][20:1]);
            end
        end

        // random traffic against the model
        for (int k = 0; k < 600; k++) begin
            int r = int'($urandom_range(0, 99));
            logic [7:0]  p = 8'($urandom_range(0, 3));
            logic [19:0] v = 20'($urandom_range(0, 5));
            if (r < 2) do_flush();
            else if (r < 45) do_fill(p, v, 20'($urandom));
            else do_look(p, v, 12'($urandom), "R2 random", h, q);
        end

        summary();
        $finish;
    end
endmodule